// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block sits beside a processor core and counts hardware activity. It has a parameterised number of 32-bit event counters (four by default) and one dedicated 32-bit cycle counter. Each event counter carries an 8-bit event type. It advances on every cycle in which the line of `event_in` at that index is high.

Software reaches the unit through a single-cycle register port. The port has an address, write data, a write strobe and a combinational read-data output. Event counters are reached indirectly: a select register picks one counter, and two shared windows then give access to its event type and its count. Counter enables and interrupt enables each have a set register and a clear register. Overflows land in a sticky flag register that is cleared by writing one to a flag bit. Every flag whose interrupt enable is set drives one shared interrupt line. The cycle counter can optionally advance once every 64 clocks.

Top module: `pmu_unit`

## Requirements
- R1: While control bit 0 (global enable; control register at address 0) is 0, neither the event counters nor the cycle counter advance. Writes to them still take effect.
- R2: Writing 1 to control bit 1 zeroes every event counter and leaves the cycle counter alone. Writing 1 to control bit 2 zeroes the cycle counter and its divide-by-64 prescaler.
- R3: With control bit 3 clear, an enabled cycle counter advances on every clock. With bit 3 set, it advances once every 64 clocks, and the first step comes 64 clocks after the write that zeroed it.
- R4: Reading the control register returns bits 5:0 as written, except bits 2:1, which always read 0. Bits 15:11 hold the number of event counters as a 5-bit value. All other bits read 0.
- R5: Writing to address 1 sets enables and writing to address 2 clears them. Bit i belongs to event counter i and bit 31 to the cycle counter; bits written as 0 change nothing. Both addresses read back the enable mask, and a counter whose enable is clear does not advance.
- R6: Interrupt enables use the same scheme: address 3 sets and address 4 clears, with the same bit positions, and both addresses read back the mask. `irq` is high exactly while some overflow flag and its interrupt enable are both 1.
- R7: The overflow flag register is at address 5 and uses the same bit positions. Reading it returns the flags. Writing 1 to a bit clears that flag, and a 0 bit leaves it unchanged. If an overflow and a clear of the same flag land in the same cycle, the flag stays set.
- R8: The 5-bit select register is at address 6. The event-type window is at address 7 and the count window at address 8; both act on the selected event counter. If the select value is not below the number of counters, writes through the windows are ignored and reads return 0.
- R9: An enabled event counter advances by one on each clock in which `event_in[type]` is high, where type is its 8-bit event type. Other event lines have no effect on it.
- R10: Every counter can be preloaded by a write: the cycle counter directly at address 9, event counters through address 8. A preload takes priority over counting in that cycle. A counter that advances from 0xFFFFFFFF wraps to 0 and sets its flag on the same clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| event_in | input | 256 | One line per event number |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Two functions can land on the same clock edge: a software write that clears an overflow flag, and a fresh overflow of that same counter. The bench provokes this in three steps. It sets the flag once, preloads the counter to 0xFFFFFFFF, and then drives the flag-clearing write in the same cycle that the counter's event line is held high. The result is judged by reading back the flag register, which must still show the flag, and the count, which must have wrapped to 0. A related collision, a cycle-counter preload in a cycle where the counter would also advance, is judged by the preload value surviving unchanged.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
// Package pmu_pkg
// Shared widths and the register address map of the performance monitor.
// Assumes a word-addressed register port with four address bits.
package pmu_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 5;
    localparam int CYC_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_EN_SET = 4'd1,
        A_EN_CLR = 4'd2,
        A_IE_SET = 4'd3,
        A_IE_CLR = 4'd4,
        A_OVF    = 4'd5,
        A_SEL    = 4'd6,
        A_TYPE   = 4'd7,
        A_CNT    = 4'd8,
        A_CYC    = 4'd9
    } pmu_addr_e;
endpackage

// File: rtl/pmu_event_counter.sv
`timescale 1ns/1ps
// Module pmu_event_counter
// One 32-bit event counter with its own event-type register.
// It advances when count_en is high and the chosen event line is high.
// Priority in a cycle: preload write, then zero request, then count.
// ovf_pulse is high in the cycle whose edge wraps the count from all ones to 0.
module pmu_event_counter #(
    parameter int EVT_W = 8,
    localparam int NEVT = 1 << EVT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      count_en,
    input  logic [NEVT-1:0]           event_in,
    input  logic                      type_we,
    input  logic                      cnt_we,
    input  logic                      zero,
    input  logic [pmu_pkg::DATA_W-1:0] wdata,
    output logic [pmu_pkg::DATA_W-1:0] cnt,
    output logic [EVT_W-1:0]          evtype,
    output logic                      ovf_pulse
);
    logic hit;

    // Event hit decode and wrap detection
    always_comb begin
        hit       = count_en & event_in[evtype];
        ovf_pulse = hit & ~cnt_we & ~zero & (&cnt);
    end

    // Count and event-type registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            evtype <= '0;
        end else begin
            if (type_we)
                evtype <= wdata[EVT_W-1:0];
            if (cnt_we)
                cnt <= wdata;
            else if (zero)
                cnt <= '0;
            else if (hit)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pmu_cycle_counter.sv
`timescale 1ns/1ps
// Module pmu_cycle_counter
// The 32-bit cycle counter with an optional divide-by-2^PRESC_W prescaler.
// With div_mode set, it steps on the edge where the prescaler wraps.
// A zero request clears both the count and the prescaler. A preload write
// has priority over zeroing and counting.
module pmu_cycle_counter #(
    parameter int PRESC_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      count_en,
    input  logic                      div_mode,
    input  logic                      zero,
    input  logic                      cnt_we,
    input  logic [pmu_pkg::DATA_W-1:0] wdata,
    output logic [pmu_pkg::DATA_W-1:0] cnt,
    output logic                      ovf_pulse
);
    logic [PRESC_W-1:0] presc;
    logic               tick;

    // Step decision and wrap detection
    always_comb begin
        tick      = count_en & (~div_mode | (&presc));
        ovf_pulse = tick & ~cnt_we & ~zero & (&cnt);
    end

    // Prescaler, runs only while dividing and enabled
    always_ff @(posedge clk) begin
        if (!rst_n || zero)
            presc <= '0;
        else if (count_en && div_mode)
            presc <= presc + 1'b1;
    end

    // Cycle count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_we)
            cnt <= wdata;
        else if (zero)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pmu_unit.sv
`timescale 1ns/1ps
// Module pmu_unit
// Performance monitor top: control register, set/clear enable pairs, sticky
// overflow flags that are cleared by writing 1, counter select indirection, NUM_CNT event
// counters and one cycle counter. Read data is combinational from addr.
// Assumes NUM_CNT is between 1 and 31, so bit 31 stays free for the cycle counter.
module pmu_unit #(
    parameter int NUM_CNT = 4,
    parameter int EVT_W   = 8,
    parameter int PRESC_W = 6,
    localparam int NEVT   = 1 << EVT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [pmu_pkg::ADDR_W-1:0] addr,
    input  logic [pmu_pkg::DATA_W-1:0] wdata,
    input  logic                       we,
    output logic [pmu_pkg::DATA_W-1:0] rdata,
    input  logic [NEVT-1:0]            event_in,
    output logic                       irq
);
    import pmu_pkg::*;

    localparam logic [DATA_W-1:0] IMPL_MASK =
        (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);

    logic              ctrl_en, ctrl_div;
    logic [1:0]        ctrl_spare;
    logic [DATA_W-1:0] en_q, ie_q, ovf_q, ovf_set;
    logic [SEL_W-1:0]  sel_q;
    logic              sel_ok;
    logic              wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
    logic              wr_ovf, wr_sel, wr_type, wr_cnt, wr_cyc;
    logic              zero_evt, zero_cyc;
    logic [DATA_W-1:0] cnt_arr [NUM_CNT];
    logic [EVT_W-1:0]  type_arr [NUM_CNT];
    logic [NUM_CNT-1:0] evt_ovf;
    logic [DATA_W-1:0] cyc_cnt;
    logic              cyc_ovf;
    logic [DATA_W-1:0] sel_cnt, sel_type;

    // Write strobe decode per register
    always_comb begin
        wr_ctrl   = we && (addr == A_CTRL);
        wr_en_set = we && (addr == A_EN_SET);
        wr_en_clr = we && (addr == A_EN_CLR);
        wr_ie_set = we && (addr == A_IE_SET);
        wr_ie_clr = we && (addr == A_IE_CLR);
        wr_ovf    = we && (addr == A_OVF);
        wr_sel    = we && (addr == A_SEL);
        wr_type   = we && (addr == A_TYPE);
        wr_cnt    = we && (addr == A_CNT);
        wr_cyc    = we && (addr == A_CYC);
        zero_evt  = wr_ctrl && wdata[1];
        zero_cyc  = wr_ctrl && wdata[2];
        sel_ok    = ({27'b0, sel_q} < NUM_CNT);
    end

    // Control and select registers; bits 1 and 2 act as pulses and are not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_div   <= 1'b0;
            ctrl_spare <= 2'b0;
            sel_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en    <= wdata[0];
                ctrl_div   <= wdata[3];
                ctrl_spare <= wdata[5:4];
            end
            if (wr_sel)
                sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Counter enable and interrupt enable masks, each with a set and a clear register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            ie_q <= '0;
        end else begin
            en_q <= ((en_q | (wr_en_set ? wdata : '0)) & ~(wr_en_clr ? wdata : '0)) & IMPL_MASK;
            ie_q <= ((ie_q | (wr_ie_set ? wdata : '0)) & ~(wr_ie_clr ? wdata : '0)) & IMPL_MASK;
        end
    end

    // Gather overflow pulses into flag bit positions
    always_comb begin
        ovf_set                 = '0;
        ovf_set[NUM_CNT-1:0]    = evt_ovf;
        ovf_set[CYC_BIT]        = cyc_ovf;
    end

    // Sticky overflow flags; a new overflow wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else
            ovf_q <= ((ovf_q & ~(wr_ovf ? wdata : '0)) | ovf_set) & IMPL_MASK;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_evt
            logic sel_me;
            assign sel_me = sel_ok && (sel_q == SEL_W'(gi));
            pmu_event_counter #(.EVT_W(EVT_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .count_en (ctrl_en & en_q[gi]),
                .event_in (event_in),
                .type_we  (wr_type & sel_me),
                .cnt_we   (wr_cnt & sel_me),
                .zero     (zero_evt),
                .wdata    (wdata),
                .cnt      (cnt_arr[gi]),
                .evtype   (type_arr[gi]),
                .ovf_pulse(evt_ovf[gi])
            );
        end
    endgenerate

    pmu_cycle_counter #(.PRESC_W(PRESC_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (ctrl_en & en_q[CYC_BIT]),
        .div_mode (ctrl_div),
        .zero     (zero_cyc),
        .cnt_we   (wr_cyc),
        .wdata    (wdata),
        .cnt      (cyc_cnt),
        .ovf_pulse(cyc_ovf)
    );

    // Pick the selected event counter's count and type, 0 when out of range
    always_comb begin
        sel_cnt  = '0;
        sel_type = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel_q == SEL_W'(i)) begin
                sel_cnt  = cnt_arr[i];
                sel_type = {{(DATA_W-EVT_W){1'b0}}, type_arr[i]};
            end
        end
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = {16'b0, 5'(NUM_CNT), 5'b0, ctrl_spare, ctrl_div, 2'b00, ctrl_en};
            A_EN_SET,
            A_EN_CLR: rdata = en_q;
            A_IE_SET,
            A_IE_CLR: rdata = ie_q;
            A_OVF:    rdata = ovf_q;
            A_SEL:    rdata = {27'b0, sel_q};
            A_TYPE:   rdata = sel_type;
            A_CNT:    rdata = sel_cnt;
            A_CYC:    rdata = cyc_cnt;
            default:  rdata = '0;
        endcase
    end

    // Combined interrupt
    assign irq = |(ovf_q & ie_q);
endmodule

// File: rtl/pmu_unit_chk.sv
`timescale 1ns/1ps
// Module pmu_unit_chk
// Assertion checker bound into pmu_unit. It watches the port and a few
// state registers of the top.
module pmu_unit_chk #(
    parameter int NUM_CNT = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       we,
    input logic [pmu_pkg::ADDR_W-1:0] addr,
    input logic [pmu_pkg::DATA_W-1:0] wdata,
    input logic [pmu_pkg::DATA_W-1:0] rdata,
    input logic                       irq,
    input logic                       ctrl_en,
    input logic [pmu_pkg::DATA_W-1:0] ie_q,
    input logic [pmu_pkg::DATA_W-1:0] ovf_q,
    input logic [pmu_pkg::DATA_W-1:0] cyc_cnt,
    input logic [pmu_pkg::DATA_W-1:0] cnt0
);
    import pmu_pkg::*;

    logic [DATA_W-1:0] keep_flags;

    // Flags that must survive this edge
    always_comb keep_flags = ovf_q & ~((we && addr == A_OVF) ? wdata : '0);

    p_hold_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !we) |=> $stable(cyc_cnt));

    p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (rdata[2:1] == 2'b00 && rdata[15:11] == 5'(NUM_CNT)));

    p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_q & $past(keep_flags)) == $past(keep_flags)));

    p_wrap_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 == 32'hFFFF_FFFF && !we) |=> (cnt0 == 32'hFFFF_FFFF || ovf_q[0]));
endmodule

bind pmu_unit pmu_unit_chk #(.NUM_CNT(NUM_CNT)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq    (irq),
    .ctrl_en(ctrl_en),
    .ie_q   (ie_q),
    .ovf_q  (ovf_q),
    .cyc_cnt(cyc_cnt),
    .cnt0   (cnt_arr[0])
);

// File: tb/pmu_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for pmu_unit: driver tasks push expected items into a queue; a
// monitor process pops each one and compares it with the port value.
module pmu_unit_tb_top;
    import pmu_pkg::*;

    localparam int NUM_CNT = 4;
    localparam int NEVT    = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic              we = 1'b0;
    logic [31:0]       rdata;
    logic [NEVT-1:0]   event_in = '0;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  smp;

    pmu_unit #(.NUM_CNT(NUM_CNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .event_in(event_in), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop the expected item and compare it with the port
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            @(smp);
            it  = exp_q.pop_front();
            got = it.is_irq ? {31'b0, irq} : rdata;
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    // Driver: one register write, called at a falling edge, returns at the next
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    // Driver: expect a register read value
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        #0.1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        ->smp;
        #0.1;
    endtask

    // Driver: expect an irq level
    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        #0.1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        ->smp;
        #0.1;
    endtask

    // Driver: hold one event line for n clock edges
    task automatic pulse(input int idx, input int n);
        event_in[idx] = 1'b1;
        repeat (n) @(negedge clk);
        event_in[idx] = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(A_CTRL, 32'h0000_2000, "R4 reset control readback");
        chk_irq(1'b0, "R6 irq low after reset");
        rd(A_CYC, 32'h0, "R10 cycle count zero after reset");

        // global enable off
        wr(A_EN_SET, 32'h1);
        wr(A_SEL, 32'd0);
        wr(A_TYPE, 32'd5);
        pulse(5, 10);
        rd(A_CNT, 32'd0, "R1 no count while globally disabled");
        rd(A_EN_SET, 32'h1, "R5 enable mask at set address");
        rd(A_EN_CLR, 32'h1, "R5 enable mask at clear address");

        wr(A_CTRL, 32'h1);
        pulse(5, 10);
        rd(A_CNT, 32'd10, "R9 counter0 counts its event");
        rd(A_CYC, 32'd0, "R5 cycle counter not enabled");

        // second counter with a different event type
        wr(A_SEL, 32'd1);
        wr(A_TYPE, 32'd7);
        wr(A_EN_SET, 32'h2);
        pulse(5, 4);
        rd(A_CNT, 32'd0, "R9 counter1 ignores other event");
        pulse(7, 3);
        rd(A_CNT, 32'd3, "R9 counter1 counts event 7");
        wr(A_SEL, 32'd0);
        rd(A_CNT, 32'd14, "R9 counter0 total");
        rd(A_TYPE, 32'd5, "R8 type window readback");

        // set/clear semantics
        wr(A_EN_SET, 32'h0);
        wr(A_EN_CLR, 32'h1);
        rd(A_EN_CLR, 32'h2, "R5 zero bits ignored, bit0 cleared");
        pulse(5, 6);
        rd(A_CNT, 32'd14, "R5 disabled counter holds");

        // select out of range
        wr(A_SEL, 32'd9);
        wr(A_CNT, 32'h55);
        wr(A_TYPE, 32'd3);
        rd(A_CNT, 32'd0, "R8 out of range count reads 0");
        rd(A_TYPE, 32'd0, "R8 out of range type reads 0");
        wr(A_SEL, 32'd1);
        rd(A_CNT, 32'd3, "R8 counter1 untouched by ignored write");
        rd(A_TYPE, 32'd7, "R8 counter1 type untouched");

        // reset bits
        wr(A_EN_SET, 32'h8000_0000);
        wr(A_CYC, 32'd100);
        rd(A_CYC, 32'd100, "R10 cycle preload");
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, 32'h0000_2001, "R4 bit1 reads back 0");
        rd(A_CNT, 32'd0, "R2 event counters zeroed");
        rd(A_CYC, 32'd101, "R2 cycle counter not zeroed by bit1");
        wr(A_CTRL, 32'h5);
        rd(A_CYC, 32'd0, "R2 cycle counter zeroed by bit2");
        repeat (3) @(negedge clk);
        rd(A_CYC, 32'd3, "R3 undivided cycle counting");

        // divide by 64
        wr(A_CTRL, 32'hD);
        rd(A_CTRL, 32'h0000_2009, "R4 stored bits readback");
        repeat (63) @(negedge clk);
        rd(A_CYC, 32'd0, "R3 no step before 64 clocks");
        @(negedge clk);
        rd(A_CYC, 32'd1, "R3 first step at 64 clocks");
        repeat (64) @(negedge clk);
        rd(A_CYC, 32'd2, "R3 second step at 128 clocks");
        wr(A_CTRL, 32'h1);

        // event counter overflow
        wr(A_SEL, 32'd2);
        wr(A_TYPE, 32'd3);
        wr(A_EN_SET, 32'h4);
        wr(A_IE_SET, 32'h4);
        wr(A_CNT, 32'hFFFF_FFFE);
        rd(A_IE_SET, 32'h4, "R6 interrupt enable mask");
        chk_irq(1'b0, "R6 irq low without flag");
        pulse(3, 1);
        rd(A_OVF, 32'h0, "R10 no flag before wrap");
        pulse(3, 1);
        rd(A_CNT, 32'd0, "R10 counter wrapped to 0");
        rd(A_OVF, 32'h4, "R7 flag set by wrap");
        chk_irq(1'b1, "R6 irq high on enabled flag");

        // clear by writing one
        wr(A_OVF, 32'h0);
        rd(A_OVF, 32'h4, "R7 zero write leaves flag");
        wr(A_OVF, 32'h4);
        rd(A_OVF, 32'h0, "R7 write one clears flag");
        chk_irq(1'b0, "R6 irq low after clear");

        // clear and overflow in the same cycle
        wr(A_CNT, 32'hFFFF_FFFF);
        pulse(3, 1);
        wr(A_CNT, 32'hFFFF_FFFF);
        event_in[3] = 1'b1;
        wr(A_OVF, 32'h4);
        event_in[3] = 1'b0;
        rd(A_OVF, 32'h4, "R7 overflow wins over same-cycle clear");
        rd(A_CNT, 32'd0, "R10 wrap during clear");

        wr(A_IE_CLR, 32'h4);
        chk_irq(1'b0, "R6 irq low after enable cleared");
        rd(A_IE_CLR, 32'h0, "R6 mask cleared");

        // cycle counter overflow
        wr(A_IE_SET, 32'h8000_0000);
        wr(A_OVF, 32'h4);
        wr(A_CYC, 32'hFFFF_FFFF);
        rd(A_OVF, 32'h0, "R10 preload beats count, no flag yet");
        @(negedge clk);
        rd(A_OVF, 32'h8000_0000, "R10 cycle counter flag at bit 31");
        rd(A_CYC, 32'd0, "R10 cycle counter wrapped");
        chk_irq(1'b1, "R6 irq from cycle flag");

        // stop globally
        wr(A_CTRL, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CYC, 32'd1, "R1 cycle counter frozen when disabled");

        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule